// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds stores that have executed but not yet been written to the data cache. Entries leave in program order through a cache write port, one at a time, whenever that port is ready. While they wait, any load can look them up. Each load presents an age tag and the block compares it only against stores that are older than the load. The answer comes back in the same cycle and takes one of three forms: use the cache, take forwarded data, or stall.

The early conflict check looks only at the page-offset bits of the address. Two accesses in different pages that share an offset therefore stall the load, and the block flags this case as a false alias. A store can also arrive before its address is known; the address is filled in later through a resolve port, which finds the entry by its age tag. Every access has a size of 1, 2, 4 or 8 bytes and is naturally aligned.

Data travels right-justified in a 64-bit field on the store input, the cache write port and the load output.

Top module: `stq_fwd`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `wr_valid` is 0, and any lookup returns `ld_result` 2'b00 with `ld_false_alias` 0.
- R2: Entries drain to the write port oldest first, at most one per cycle. An entry leaves only on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_size` and `wr_data` hold steady.
- R3: With DEPTH entries held, `st_ready` is 0, even in a cycle where an entry drains. A store offered while `st_ready` is 0 is not enqueued.
- R4: A load forwards (`ld_result` 2'b01) when the selected store has the same full address and the same size. `ld_data` then equals the stored value. Sizes are encoded 0=1, 1=2, 2=4 and 3=8 bytes.
- R5: A load whose bytes lie entirely inside the selected store's bytes also forwards. In that case `ld_data` = (store data >> 8*(load addr[2:0] - store addr[2:0])), masked to the load size.
- R6: Among older stores that overlap the load at the full address, the youngest one is selected.
- R7: A store counts as older only when (load age - store age) mod 2^AGEW is nonzero and its top bit is 0. Stores that are not older are ignored, and this rule holds across wrap-around of the age counter.
- R8: If the selected store overlaps the load only partly, the lookup returns stall (2'b10) with `ld_false_alias` 0. Once that store has drained, the same lookup no longer stalls on it.
- R9: An older store with known address whose bytes overlap the load on address bits [11:0], but whose bits above 11 differ from the load's, causes a stall. In that case `ld_false_alias` is 1, unless another condition also causes a stall.
- R10: An older store whose address is not yet known causes a stall with `ld_false_alias` 0. A resolve with that store's age supplies the address, and later lookups use it.
- R11: The oldest entry does not drain while its address is unknown.
- R12: A load that overlaps no older store returns 2'b00. The code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Queue can accept a store |
| st_age | input | AGEW | Store age tag |
| st_addr | input | AW | Store byte address |
| st_addr_ok | input | 1 | Store address is known |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, right-justified |
| res_valid | input | 1 | Address resolve strobe |
| res_age | input | AGEW | Age of the store being resolved |
| res_addr | input | AW | Resolved address |
| ld_age | input | AGEW | Load age tag |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_result | output | 2 | 00 cache, 01 forward, 10 stall |
| ld_false_alias | output | 1 | Stall caused only by an offset-only match |
| ld_data | output | 64 | Forwarded data, right-justified |
| wr_valid | output | 1 | Oldest entry ready to write |
| wr_ready | input | 1 | Cache write port accepts |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 64 | Write data |

## Verification
The assertions check on every cycle that a write waiting on the port stays unchanged, that the occupancy never exceeds the depth and drops by exactly one on each drain, and that the result code is always legal with the false-alias flag raised only alongside a stall. Other behaviours can only be shown by the bench's scenarios. These are: the values forwarded for every aligned load size and offset against one full-width store and against a nested pair of stores; which store is selected by age, including across wrap-around; the point at which a partial-overlap stall ends after a drain; and the order in which entries leave a full queue.

// File: rtl/stq_fwd.sv
module stq_fwd #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int AGEW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AGEW-1:0] st_age,
  input  logic [AW-1:0]   st_addr,
  input  logic            st_addr_ok,
  input  logic [1:0]      st_size,
  input  logic [63:0]     st_data,
  input  logic            res_valid,
  input  logic [AGEW-1:0] res_age,
  input  logic [AW-1:0]   res_addr,
  input  logic [AGEW-1:0] ld_age,
  input  logic [AW-1:0]   ld_addr,
  input  logic [1:0]      ld_size,
  output logic [1:0]      ld_result,
  output logic            ld_false_alias,
  output logic [63:0]     ld_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [1:0]      wr_size,
  output logic [63:0]     wr_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int OFS = 12;

  logic [AW-1:0]   e_addr [DEPTH];
  logic [AGEW-1:0] e_age  [DEPTH];
  logic [1:0]      e_size [DEPTH];
  logic [63:0]     e_data [DEPTH];
  logic [DEPTH-1:0] ok_q, live;
  logic [PW-1:0]   head, tail;
  logic [CW-1:0]   cnt;

  function automatic logic [7:0] bmask(input logic [1:0] sz, input logic [2:0] a);
    logic [7:0] m;
    case (sz)
      2'd0: m = 8'h01;
      2'd1: m = 8'h03;
      2'd2: m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m << a;
  endfunction

  function automatic logic is_older(input logic [AGEW-1:0] sa, input logic [AGEW-1:0] la);
    logic [AGEW-1:0] d;
    d = la - sa;
    return (d != '0) && !d[AGEW-1];
  endfunction

  wire push = st_valid && st_ready;
  wire pop  = wr_valid && wr_ready;

  assign st_ready = cnt < CW'(DEPTH);
  assign wr_valid = (cnt != '0) && ok_q[head];
  assign wr_addr  = e_addr[head];
  assign wr_size  = e_size[head];
  assign wr_data  = e_data[head];

  always_comb
    for (int i = 0; i < DEPTH; i++)
      live[i] = {1'b0, PW'(i) - head} < cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      ok_q <= '0;
    end else begin
      if (res_valid)
        for (int i = 0; i < DEPTH; i++)
          if (live[i] && !ok_q[i] && e_age[i] == res_age) begin
            e_addr[i] <= res_addr;
            ok_q[i]   <= 1'b1;
          end
      if (push) begin
        e_addr[tail] <= st_addr;
        e_age[tail]  <= st_age;
        e_size[tail] <= st_size;
        e_data[tail] <= st_data;
        ok_q[tail]   <= st_addr_ok;
        tail         <= tail + 1'b1;
      end
      if (pop) head <= head + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  logic          unk, fa, hit, part;
  logic [PW-1:0] yi;
  logic [7:0]    lm;

  always_comb begin
    logic [PW-1:0] idx;
    unk = 1'b0;
    fa  = 1'b0;
    hit = 1'b0;
    yi  = '0;
    lm  = bmask(ld_size, ld_addr[2:0]);
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (CW'(k) < cnt && is_older(e_age[idx], ld_age)) begin
        if (!ok_q[idx]) unk = 1'b1;
        else if ((bmask(e_size[idx], e_addr[idx][2:0]) & lm) != '0 &&
                 e_addr[idx][OFS-1:3] == ld_addr[OFS-1:3]) begin
          if (e_addr[idx][AW-1:OFS] == ld_addr[AW-1:OFS]) begin
            hit = 1'b1;
            yi  = idx;
          end else fa = 1'b1;
        end
      end
    end
    part = hit && ((lm & ~bmask(e_size[yi], e_addr[yi][2:0])) != '0);
  end

  wire [2:0]  sh    = ld_addr[2:0] - e_addr[yi][2:0];
  wire [63:0] dmask = (ld_size == 2'd3) ? '1 : ((64'd1 << (6'd8 << ld_size)) - 64'd1);
  wire        stall = unk || fa || part;

  assign ld_result      = stall ? 2'b10 : (hit ? 2'b01 : 2'b00);
  assign ld_false_alias = fa && !unk && !part;
  assign ld_data        = (e_data[yi] >> {sh, 3'b000}) & dmask;

  // R2
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_size));
  // R2
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !push |=> cnt == $past(cnt) - 1'b1);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R9
  alias_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_false_alias |-> ld_result == 2'b10);
  // R12
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_result != 2'b11);
endmodule

// File: tb/sim_stq_fwd.sv
module sim_stq_fwd;
  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_addr_ok = 0, res_valid = 0, wr_ready = 0;
  logic [3:0] st_age = 0, res_age = 0, ld_age = 0;
  logic [31:0] st_addr = 0, res_addr = 0, ld_addr = 0;
  logic [1:0] st_size = 0, ld_size = 0;
  logic [63:0] st_data = 0;
  logic st_ready, ld_false_alias, wr_valid;
  logic [1:0] ld_result, wr_size;
  logic [63:0] ld_data, wr_data;
  logic [31:0] wr_addr;
  int errors = 0, checks = 0;

  localparam logic [63:0] DA = 64'h8877665544332211;
  localparam logic [63:0] DB = 64'h00000000CAFEF00D;

  stq_fwd u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] age, input logic [31:0] a, input bit ok,
                      input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk);
    st_valid = 1; st_age = age; st_addr = a; st_addr_ok = ok; st_size = sz; st_data = d;
    @(posedge clk);
    #1 st_valid = 0;
  endtask

  task automatic look(input logic [3:0] age, input logic [31:0] a, input logic [1:0] sz,
                      input logic [1:0] er, input bit ef, input logic [63:0] ed, input string req);
    ld_age = age; ld_addr = a; ld_size = sz;
    #1;
    chk(ld_result == er && ld_false_alias == ef && (er != 2'b01 || ld_data == ed), req,
        {ld_result, ld_false_alias, ld_data[60:0]}, {er, ef, ed[60:0]});
  endtask

  function automatic logic [63:0] szmask(input int sz);
    return (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(st_ready == 1 && wr_valid == 0, "R1", {st_ready, wr_valid}, 2'b10);
    look(4'd5, 32'h1008, 2'd3, 2'b00, 0, 0, "R1");

    // R4 R5 sweep against one 8-byte store
    push(4'd1, 32'h1008, 1, 2'd3, DA);
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 8; off += (1 << sz))
        look(4'd5, 32'h1008 + off, 2'(sz), 2'b01, 0, (DA >> (8 * off)) & szmask(sz), "R5");
    look(4'd5, 32'h1008, 2'd3, 2'b01, 0, DA, "R4");
    look(4'd1, 32'h1008, 2'd3, 2'b00, 0, 0, "R7 same age");
    look(4'd0, 32'h1008, 2'd3, 2'b00, 0, 0, "R7 younger");
    chk(wr_valid == 1 && wr_addr == 32'h1008, "R2 hold", wr_addr, 32'h1008);

    // R6 R8 sweep against nested pair
    push(4'd2, 32'h100C, 1, 2'd2, DB);
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 8; off += (1 << sz)) begin
        logic [15:0] lm;
        lm = 16'(((1 << (1 << sz)) - 1) << off);
        if ((lm & ~16'h00F0) == 0)
          look(4'd5, 32'h1008 + off, 2'(sz), 2'b01, 0, (DB >> (8 * (off - 4))) & szmask(sz), "R6");
        else if ((lm & 16'h00F0) == 0)
          look(4'd5, 32'h1008 + off, 2'(sz), 2'b01, 0, (DA >> (8 * off)) & szmask(sz), "R6");
        else
          look(4'd5, 32'h1008 + off, 2'(sz), 2'b10, 0, 0, "R8");
      end
    look(4'd2, 32'h100C, 2'd2, 2'b01, 0, 64'h88776655, "R7 skip younger store");
    chk(wr_valid == 1 && wr_addr == 32'h1008, "R2 hold", wr_addr, 32'h1008);

    // R9 false alias, R12 no overlap
    look(4'd5, 32'h5008, 2'd3, 2'b10, 1, 0, "R9");
    look(4'd5, 32'h700C, 2'd2, 2'b10, 1, 0, "R9");
    look(4'd5, 32'h5010, 2'd3, 2'b00, 0, 0, "R12");
    look(4'd5, 32'h1010, 2'd3, 2'b00, 0, 0, "R12");

    // R10 unknown address
    push(4'd3, 32'h0, 0, 2'd1, 64'hBEEF);
    look(4'd5, 32'h7770, 2'd3, 2'b10, 0, 0, "R10");
    look(4'd3, 32'h7770, 2'd3, 2'b00, 0, 0, "R10 not older");
    @(negedge clk);
    res_valid = 1; res_age = 4'd3; res_addr = 32'h3000;
    @(posedge clk);
    #1 res_valid = 0;
    look(4'd5, 32'h7770, 2'd3, 2'b00, 0, 0, "R10");
    look(4'd5, 32'h3000, 2'd1, 2'b01, 0, 64'hBEEF, "R10");

    // R2 drain order, R8 stall clears
    @(negedge clk);
    wr_ready = 1;
    #1 chk(wr_valid && wr_addr == 32'h1008 && wr_data == DA && wr_size == 2'd3, "R2", wr_addr, 32'h1008);
    @(posedge clk);
    #1 chk(wr_valid && wr_addr == 32'h100C && wr_data == DB, "R2", wr_addr, 32'h100C);
    @(posedge clk);
    #1 chk(wr_valid && wr_addr == 32'h3000 && wr_data == 64'hBEEF, "R2", wr_addr, 32'h3000);
    look(4'd5, 32'h1008, 2'd3, 2'b00, 0, 0, "R8 after drain");
    @(posedge clk);
    #1 chk(wr_valid == 0, "R2 empty", wr_valid, 0);

    // R11 unknown head blocks drain
    push(4'd4, 32'h0, 0, 2'd0, 64'h5A);
    chk(wr_valid == 0, "R11", wr_valid, 0);
    @(posedge clk);
    #1 chk(wr_valid == 0, "R11", wr_valid, 0);
    @(negedge clk);
    res_valid = 1; res_age = 4'd4; res_addr = 32'h4000;
    @(posedge clk);
    #1 res_valid = 0;
    chk(wr_valid == 1 && wr_addr == 32'h4000, "R10 resolve drain", wr_addr, 32'h4000);
    @(posedge clk);
    #1 chk(wr_valid == 0, "R11", wr_valid, 0);

    // R7 wrap, R3 full
    @(negedge clk);
    wr_ready = 0;
    push(4'd14, 32'h6000, 1, 2'd3, 64'h0102030405060708);
    look(4'd1, 32'h6004, 2'd2, 2'b01, 0, 64'h01020304, "R7 wrap");
    look(4'd13, 32'h6000, 2'd3, 2'b00, 0, 0, "R7 wrap");
    for (int i = 0; i < 7; i++)
      push(4'(15 + i), 32'h6100 + 8 * i, 1, 2'd3, 64'(i));
    chk(st_ready == 0, "R3", st_ready, 0);
    @(negedge clk);
    st_valid = 1; st_addr = 32'h9990; st_addr_ok = 1; wr_ready = 1;
    #1 chk(st_ready == 0, "R3 during drain", st_ready, 0);
    @(posedge clk);
    #1 st_valid = 0;
    for (int i = 0; i < 7; i++) begin
      chk(wr_valid && wr_addr == 32'h6100 + 8 * i && wr_data == 64'(i), "R2 order", wr_addr, 32'h6100 + 8 * i);
      @(posedge clk);
      #1;
    end
    chk(wr_valid == 0 && st_ready == 1, "R3 rejected store", {wr_valid, st_ready}, 2'b01);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule